// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block is the timebase and interrupt-status section of a real-time clock. An oscillator tick enable advances a binary divider chain. A 3-bit divider field tells the block which oscillator frequency it is fed with, and the same field can hold the chain cleared or freeze it. A 4-bit rate code picks one stage of the chain. That stage drives a periodic event, and when enabled it also drives a square-wave pin with a 50% duty cycle.

A status byte collects three flags: the periodic flag from the chain, and alarm and update-ended flags reported by the neighbouring time counters. A summary bit and the `irq` pin go high while any flag is set together with its own enable. Reading the status byte acknowledges the interrupt by clearing every flag. An event that lands in the same cycle as the read survives the clear.

Top module: `rtc_periodic_gen`

## Requirements
- R1: After reset, `status_q` reads 8'h00, and `irq` and `sqw_out` are low.
- R2: `ctrl_a[6:4]` names the oscillator: 000 = 4.194304 MHz, 001 = 1.048576 MHz, 010 = 32.768 kHz. For `ctrl_a[3:0]` = 3..15, the periodic rate is 8192 Hz halved per code step. The periodic edge therefore repeats every oscillator/rate ticks. The first edge comes half a period after the chain starts from zero. `sqw_out` rises in exactly the cycle the flag becomes visible.
- R3: Rate codes 1 and 2 give 256 Hz and 128 Hz with the 32.768 kHz oscillator, and 32768 Hz and 16384 Hz with the other two oscillators.
- R4: Divider codes 110 and 111 hold the chain at zero. Leaving them restarts the count from zero. Codes 011 to 101 freeze the count without clearing it and produce no periodic edges. A run resumed after a freeze continues from the frozen count.
- R5: Rate code 0 produces no periodic flag and keeps `sqw_out` low.
- R6: `sqw_out` stays low while `sq_out_en` is low.
- R7: The periodic flag sets on every periodic edge, whether or not `per_irq_en` is set.
- R8: `status_q` layout: bit 6 is the periodic flag, bit 5 is the alarm flag (set by `alarm_evt`), and bit 4 is the update-ended flag (set by `update_evt`). Bits 3:0 read zero. Bit 7 is high while any flag is set together with its enable (`per_irq_en`, `alm_irq_en` or `upd_irq_en` respectively).
- R9: `irq` follows `status_q[7]`.
- R10: A cycle with `status_rd` high presents the flags as they stood before the read. At that clock edge every flag is cleared.
- R11: A flag event in the same cycle as `status_rd` leaves that flag set after the read.
- R12: The chain advances only in cycles with `osc_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One pulse per oscillator period |
| ctrl_a | input | 7 | [6:4] divider/oscillator code, [3:0] rate code |
| per_irq_en | input | 1 | Periodic flag participates in the request |
| alm_irq_en | input | 1 | Alarm flag participates in the request |
| upd_irq_en | input | 1 | Update-ended flag participates in the request |
| sq_out_en | input | 1 | Enables the square-wave pin |
| alarm_evt | input | 1 | Alarm match pulse from the time counters |
| update_evt | input | 1 | Update-ended pulse from the time counters |
| status_rd | input | 1 | Status byte is read this cycle |
| status_q | output | 8 | Status byte: request, three flags, zero nibble |
| irq | output | 1 | Interrupt request, active high |
| sqw_out | output | 1 | Square wave at the selected rate |

## Verification
The scoreboard predicts the exact cycle of every square-wave rise from frequency ratios. An off-by-one tap would shift edges by a factor of two, and a wrong timebase mapping for the low rate codes would miss them entirely. A freeze test stops the chain mid-period and then resumes it. A design that cleared on the freeze codes, or kept counting through them, would put the next edge at the wrong cycle. The status tests raise flags with their enables off and then on, and read while a fresh update event arrives. This exposes a design that gates flag setting by the enable, presents post-clear data, or drops a coincident event.

// File: rtl/rtc_rate_pkg.sv
package rtc_rate_pkg;

  localparam int SHIFT_W = 5;

  localparam logic [2:0] DIV_FAST = 3'b000;
  localparam logic [2:0] DIV_MID  = 3'b001;
  localparam logic [2:0] DIV_SLOW = 3'b010;

  localparam logic [SHIFT_W-1:0] BASE_FAST = 5'd7;
  localparam logic [SHIFT_W-1:0] BASE_MID  = 5'd5;
  localparam logic [SHIFT_W-1:0] BASE_SLOW = 5'd0;
  localparam logic [SHIFT_W-1:0] SLOW_LOW_OFS = 5'd6;

  typedef struct packed {
    logic pf;
    logic af;
    logic uf;
  } rtc_flags_t;

  function automatic logic div_runs(input logic [2:0] d);
    return (d == DIV_FAST) || (d == DIV_MID) || (d == DIV_SLOW);
  endfunction

  function automatic logic div_held(input logic [2:0] d);
    return d[2:1] == 2'b11;
  endfunction

  // Period of the selected tap as a power of two in oscillator ticks; 0 = off.
  function automatic logic [SHIFT_W-1:0] tap_shift(input logic [2:0] d,
                                                   input logic [3:0] r);
    logic [SHIFT_W-1:0] base;
    logic [SHIFT_W-1:0] rr;
    rr = {1'b0, r};
    case (d)
      DIV_FAST: base = BASE_FAST;
      DIV_MID:  base = BASE_MID;
      default:  base = BASE_SLOW;
    endcase
    if (!div_runs(d) || (r == 4'd0)) return '0;
    if ((d == DIV_SLOW) && (r < 4'd3)) return rr + SLOW_LOW_OFS;
    return base + rr - 5'd1;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CHAIN_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [2:0]         div_code,
  output logic [CHAIN_W-1:0] cnt,
  output logic               chain_held
);
  import rtc_rate_pkg::*;

  logic chain_run;

  assign chain_held = div_held(div_code);
  assign chain_run  = div_runs(div_code);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (chain_held) cnt <= '0;
    else if (chain_run && tick) cnt <= cnt + 1'b1;
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_held |=> (cnt == '0));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chain_held && !chain_run) |=> $stable(cnt));

  assert_no_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !chain_held) |=> $stable(cnt));

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap #(
  parameter int CHAIN_W = 22
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CHAIN_W-1:0] cnt,
  input  logic [2:0]         div_code,
  input  logic [3:0]         rate_code,
  input  logic               tick,
  input  logic               sq_en,
  output logic               per_evt,
  output logic               tap_level,
  output logic               sq_wave
);
  import rtc_rate_pkg::*;

  localparam logic [CHAIN_W-1:0] ONE = CHAIN_W'(1);

  logic [SHIFT_W-1:0] shl;
  logic               tap_on;
  logic [CHAIN_W-1:0] full_mask;
  logic [CHAIN_W-1:0] half_mask;
  logic [CHAIN_W-1:0] tap_bit;

  assign shl       = tap_shift(div_code, rate_code);
  assign tap_on    = (shl != '0);
  assign full_mask = (ONE << shl) - ONE;
  assign half_mask = (ONE << (shl - 5'd1)) - ONE;
  assign tap_bit   = ONE << (shl - 5'd1);

  assign tap_level = tap_on && ((cnt & tap_bit) != '0);
  // The tap bit rises when the low bits roll from just-below-half to half.
  assign per_evt   = tick && tap_on && ((cnt & full_mask) == half_mask);
  assign sq_wave   = sq_en && tap_level;

  assert_rate_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == 4'd0) |-> !per_evt);

endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status (
  input  logic                     clk,
  input  logic                     rst_n,
  input  rtc_rate_pkg::rtc_flags_t evts,
  input  rtc_rate_pkg::rtc_flags_t enables,
  input  logic                     rd,
  output rtc_rate_pkg::rtc_flags_t flags,
  output logic                     req
);
  import rtc_rate_pkg::*;

  rtc_flags_t kept;

  assign kept = rd ? rtc_flags_t'('0) : flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= kept | evts;
  end

  assign req = |(flags & enables);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (evts == '0)) |=> (flags == '0));

  assert_coincident_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && evts.uf) |=> flags.uf);

  assert_pf_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evts.pf |=> flags.pf);

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen #(
  parameter int CHAIN_W = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic [6:0] ctrl_a,
  input  logic       per_irq_en,
  input  logic       alm_irq_en,
  input  logic       upd_irq_en,
  input  logic       sq_out_en,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic       status_rd,
  output logic [7:0] status_q,
  output logic       irq,
  output logic       sqw_out
);
  import rtc_rate_pkg::*;

  logic [2:0]         div_code;
  logic [3:0]         rate_code;
  logic [CHAIN_W-1:0] chain_cnt;
  logic               chain_held;
  logic               per_evt;
  logic               tap_level;
  rtc_flags_t         evts;
  rtc_flags_t         enables;
  rtc_flags_t         flags;
  logic               req;

  assign div_code  = ctrl_a[6:4];
  assign rate_code = ctrl_a[3:0];

  rtc_prescaler #(.CHAIN_W(CHAIN_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .div_code(div_code),
    .cnt(chain_cnt), .chain_held(chain_held)
  );

  rtc_rate_tap #(.CHAIN_W(CHAIN_W)) u_tap (
    .clk(clk), .rst_n(rst_n), .cnt(chain_cnt), .div_code(div_code),
    .rate_code(rate_code), .tick(osc_tick), .sq_en(sq_out_en),
    .per_evt(per_evt), .tap_level(tap_level), .sq_wave(sqw_out)
  );

  assign evts    = '{pf: per_evt, af: alarm_evt, uf: update_evt};
  assign enables = '{pf: per_irq_en, af: alm_irq_en, uf: upd_irq_en};

  rtc_irq_status u_stat (
    .clk(clk), .rst_n(rst_n), .evts(evts), .enables(enables),
    .rd(status_rd), .flags(flags), .req(req)
  );

  assign status_q = {req, flags.pf, flags.af, flags.uf, 4'b0000};
  assign irq      = req;

  assert_edge_tap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (per_evt && !chain_held) |=> (tap_level || !$stable(ctrl_a)));

  assert_held_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chain_held |-> !per_evt);

endmodule

// File: tb/tb_rtc_periodic_gen.sv
`timescale 1ns/1ps
module tb_rtc_periodic_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b1;
  logic [6:0] ctrl_a = 7'h60;
  logic per_irq_en = 1'b0, alm_irq_en = 1'b0, upd_irq_en = 1'b0, sq_out_en = 1'b1;
  logic alarm_evt = 1'b0, update_evt = 1'b0, status_rd = 1'b0;
  logic [7:0] status_q;
  logic irq, sqw_out;

  always #2 clk = ~clk;

  rtc_periodic_gen dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .ctrl_a(ctrl_a),
    .per_irq_en(per_irq_en), .alm_irq_en(alm_irq_en), .upd_irq_en(upd_irq_en),
    .sq_out_en(sq_out_en), .alarm_evt(alarm_evt), .update_evt(update_evt),
    .status_rd(status_rd), .status_q(status_q), .irq(irq), .sqw_out(sqw_out)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit prev_sqw = 1'b0;
  int mon_e;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every square-wave rise is matched against the predicted cycle.
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (sqw_out && !prev_sqw) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 R3 unexpected periodic edge", cyc, -1);
        else begin
          mon_e = exp_q.pop_front();
          chk(cyc == mon_e, "R2 R3 periodic edge cycle", cyc, mon_e);
        end
      end
      prev_sqw = sqw_out;
    end
  end

  // Oscillator ticks per periodic edge, from frequencies.
  function automatic int exp_period(input logic [2:0] d, input logic [3:0] r);
    int osc, hz;
    osc = (d == 3'b000) ? 4194304 : (d == 3'b001) ? 1048576 : 32768;
    if (r >= 4'd3)          hz = 8192 >> (r - 3);
    else if (d == 3'b010)   hz = 256 >> (r - 1);
    else                    hz = 32768 >> (r - 1);
    return osc / hz;
  endfunction

  task automatic run_rate(input logic [2:0] d, input logic [3:0] r,
                          input int n, input string req);
    int c0, p;
    @(negedge clk); ctrl_a = {3'b110, r};
    @(negedge clk); ctrl_a = {d, r};
    c0 = cyc;
    p = exp_period(d, r);
    for (int j = 0; j < n; j++) exp_q.push_back(c0 + p / 2 + j * p);
    repeat (p / 2 + (n - 1) * p + 3) @(negedge clk);
    ctrl_a = 7'h60;
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic read_status();
    @(negedge clk); status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
  endtask

  initial begin
    int c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(status_q == 8'h00, "R1 status after reset", status_q, 8'h00);
    chk(irq == 1'b0, "R1 irq after reset", irq, 0);
    chk(sqw_out == 1'b0, "R1 sqw after reset", sqw_out, 0);

    // R2: rate codes 3..15 on each oscillator
    run_rate(3'b000, 4'd3, 3, "R2 fast osc code 3");
    run_rate(3'b001, 4'd6, 2, "R2 mid osc code 6");
    run_rate(3'b010, 4'd3, 4, "R2 slow osc code 3");
    run_rate(3'b010, 4'd9, 2, "R2 slow osc code 9");
    run_rate(3'b010, 4'd15, 2, "R2 slow osc code 15");
    // R3: low codes depend on oscillator
    run_rate(3'b000, 4'd1, 4, "R3 fast osc code 1");
    run_rate(3'b000, 4'd2, 3, "R3 fast osc code 2");
    run_rate(3'b001, 4'd2, 3, "R3 mid osc code 2");
    run_rate(3'b010, 4'd1, 3, "R3 slow osc code 1");
    run_rate(3'b010, 4'd2, 3, "R3 slow osc code 2");

    // R5: rate code 0
    read_status();
    @(negedge clk); ctrl_a = {3'b010, 4'd0};
    repeat (50) @(negedge clk);
    chk(status_q == 8'h00, "R5 no flag with rate 0", status_q, 8'h00);
    ctrl_a = 7'h60;

    // R4: freeze keeps the count, resume continues
    @(negedge clk); ctrl_a = {3'b000, 4'd3};
    repeat (100) @(negedge clk);
    ctrl_a = {3'b011, 4'd3};
    repeat (500) @(negedge clk);
    chk(status_q[6] == 1'b0, "R4 no flag while frozen", status_q[6], 0);
    ctrl_a = {3'b000, 4'd3};
    c1 = cyc;
    exp_q.push_back(c1 + exp_period(3'b000, 4'd3) / 2 - 100);
    repeat (160) @(negedge clk);
    ctrl_a = 7'h60;
    chk(exp_q.size() == 0, "R4 resume from frozen count", exp_q.size(), 0);
    read_status();

    // R12: no ticks, no progress
    @(negedge clk); osc_tick = 1'b0; ctrl_a = {3'b010, 4'd3};
    repeat (50) @(negedge clk);
    chk(status_q == 8'h00, "R12 chain idle without ticks", status_q, 8'h00);
    osc_tick = 1'b1;
    exp_q.push_back(cyc + 2);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R12 edge after ticks resume", exp_q.size(), 0);
    ctrl_a = 7'h60;
    read_status();

    // R6, R7, R8, R9: periodic flag and enables
    @(negedge clk); sq_out_en = 1'b0; ctrl_a = {3'b010, 4'd3};
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(sqw_out == 1'b0, "R6 sqw low when disabled", sqw_out, 0);
    end
    chk(status_q == 8'h40, "R7 flag sets without enable", status_q, 8'h40);
    chk(irq == 1'b0, "R9 irq low without enable", irq, 0);
    per_irq_en = 1'b1;
    @(negedge clk);
    chk(status_q == 8'hC0, "R8 request bit with periodic enable", status_q, 8'hC0);
    chk(irq == 1'b1, "R9 irq follows request", irq, 1);
    ctrl_a = 7'h60;
    @(negedge clk);
    // R10: read presents pre-clear value, then clears
    chk(status_q == 8'hC0, "R10 value during read", status_q, 8'hC0);
    status_rd = 1'b1;
    @(negedge clk); status_rd = 1'b0;
    chk(status_q == 8'h00, "R10 cleared after read", status_q, 8'h00);
    chk(irq == 1'b0, "R10 irq dropped after read", irq, 0);
    per_irq_en = 1'b0;

    // R8 alarm bit and enable
    alarm_evt = 1'b1;
    @(negedge clk); alarm_evt = 1'b0;
    @(negedge clk);
    chk(status_q == 8'h20, "R8 alarm flag bit 5", status_q, 8'h20);
    alm_irq_en = 1'b1;
    @(negedge clk);
    chk(status_q == 8'hA0, "R8 alarm request", status_q, 8'hA0);
    chk(irq == 1'b1, "R9 irq on alarm", irq, 1);

    // R11: update event coincident with read
    status_rd = 1'b1; update_evt = 1'b1;
    @(negedge clk); status_rd = 1'b0; update_evt = 1'b0;
    chk(status_q == 8'h10, "R11 coincident event kept", status_q, 8'h10);
    upd_irq_en = 1'b1;
    @(negedge clk);
    chk(status_q == 8'h90, "R8 update request bit 4", status_q, 8'h90);
    read_status();
    chk(status_q == 8'h00, "R10 update flag cleared", status_q, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule